// File: doc/BRIEF.md
# Dual-Mode Serial Word Extractor

This block sits behind an FSK demodulator and turns its asynchronous 1200-baud bit stream into 8-bit words presented on a three-wire port: a data line, a data clock and a data-ready flag. A 16x oversampling tick sets the bit timing. Each frame starts with a low start bit, carries eight data bits least significant bit first, and closes with one or more high stop bits. Mark bits between frames are treated as line idle.

A mode input selects how words leave the block. With the mode low, the block drives the port itself. The data line mirrors the incoming stream. A gapped clock of eight pulses per word rises in the centre of each data bit. A one-cycle ready pulse marks each complete frame. With the mode high, the block holds the last word. It raises data-ready and lets an external host shift the bits out with its own clock pulses.

Top module: `fsk_word_port`

## Requirements
- R1: A falling edge on the line is accepted as a start bit only if the line is still low at the middle of the start bit (8 ticks later). A shorter low pulse yields no clock pulses and no ready indication.
- R2: In mode 0 every accepted frame gives exactly 8 rising edges on `dclk_o`, one per data bit near its centre and none during start or stop bits. Capturing `data_o` on those edges rebuilds the sent byte, with bit 0 arriving first.
- R3: In mode 0, `data_o` equals `line_i` at all times.
- R4: In mode 0, `dr_o` is high for exactly one clock cycle per valid frame, at the centre of its first stop bit.
- R5: Frames with 1 to 10 stop bits are received alike, and extra high bits produce no extra words or clock pulses.
- R6: Frames whose bit period is off by about ±1.5 % of nominal are still received correctly.
- R7: If the first stop bit samples low, the word is dropped and no ready is given. The receiver waits for the line to go high before it accepts the next start bit, and the next valid frame is received normally.
- R8: In mode 1, a received word sets `dr_o` high, and `data_o` shows bit 0 of the word. Each rising edge of `hclk_i` advances `data_o` to the next higher bit.
- R9: In mode 1, `dr_o` falls after the first `hclk_i` rising edge that follows a new word.
- R10: In mode 1, a word that arrives before the read is finished replaces the held word. It sets `dr_o` again and returns `data_o` to bit 0 of the new word.
- R11: During and right after reset, `dr_o` and `dclk_o` are low.
- R12: In mode 1, `dclk_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | One-cycle enable at 16 times the baud rate |
| mode_i | input | 1 | 0: block drives the port, 1: host clocks words out |
| line_i | input | 1 | Demodulated serial bit stream, idle high |
| hclk_i | input | 1 | Host shift clock used in mode 1 |
| data_o | output | 1 | Serial data out |
| dclk_o | output | 1 | Generated data clock in mode 0, low in mode 1 |
| dr_o | output | 1 | Data-ready: pulse in mode 0, held flag in mode 1 |

## Verification
A wrong bit counter or sample phase shows within one frame, about ten bit times: the count of `dclk_o` edges differs from eight or the captured byte is wrong. A receiver stuck after a framing error shows as a missing ready on the very next good frame. A wrong pointer in the host shift register shows on `data_o` after the next host clock edge, and a wrong ready flag shows as soon as a word lands or a host edge is seen.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_WAITHI
   } rx_state_e;
endpackage

// File: rtl/fwp_sync.sv
module fwp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else if (STAGES == 1) begin : g_one
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= RST_VAL;
         else        r <= d;
      end
      assign q = r;
   end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= {STAGES{RST_VAL}};
         else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
   end
endmodule

// File: rtl/fwp_rx_frame.sv
module fwp_rx_frame
   import fwp_pkg::*;
#(
   parameter int OSR    = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   output logic              bit_stb,
   output logic              word_vld,
   output logic              frm_err,
   output logic [DATA_W-1:0] word
);
   localparam int             CW   = $clog2(OSR);
   localparam int             IW   = $clog2(DATA_W);
   localparam logic [CW-1:0]  MID  = CW'(OSR/2 - 1);
   localparam logic [CW-1:0]  LAST = CW'(OSR - 1);
   localparam logic [IW-1:0]  TOP  = IW'(DATA_W - 1);

   rx_state_e         state;
   logic [CW-1:0]     cnt;
   logic [IW-1:0]     idx;
   logic [DATA_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         cnt      <= '0;
         idx      <= '0;
         shreg    <= '0;
         bit_stb  <= 1'b0;
         word_vld <= 1'b0;
         frm_err  <= 1'b0;
      end else begin
         bit_stb  <= 1'b0;
         word_vld <= 1'b0;
         frm_err  <= 1'b0;
         if (tick) begin
            unique case (state)
               RX_IDLE: begin
                  if (!line) begin
                     state <= RX_START;
                     cnt   <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == MID) begin
                     cnt <= '0;
                     idx <= '0;
                     state <= line ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt == LAST) begin
                     cnt     <= '0;
                     shreg   <= {line, shreg[DATA_W-1:1]};
                     bit_stb <= 1'b1;
                     if (idx == TOP) state <= RX_STOP;
                     else            idx   <= idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == LAST) begin
                     cnt <= '0;
                     if (line) begin
                        word_vld <= 1'b1;
                        state    <= RX_IDLE;
                     end else begin
                        frm_err  <= 1'b1;
                        state    <= RX_WAITHI;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_WAITHI: begin
                  if (line) state <= RX_IDLE;
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   assign word = shreg;

   AST_START_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_START && tick && cnt == MID && line) |=> (state == RX_IDLE)); // R1

   AST_FRAME_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_STOP && tick && cnt == LAST && !line) |=> (frm_err && !word_vld && state == RX_WAITHI)); // R7

   AST_WAIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_WAITHI && !line) |=> (state == RX_WAITHI)); // R7
endmodule

// File: rtl/fwp_dclk_gen.sv
module fwp_dclk_gen #(
   parameter int OSR        = 16,
   parameter int DATA_W     = 8,
   parameter int HIGH_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic bit_stb,
   input  logic word_end,
   output logic dclk
);
   localparam int HW = $clog2(OSR);
   localparam int PW = $clog2(DATA_W + 1) + 1;
   localparam logic [HW-1:0] HLAST = HW'(HIGH_TICKS - 1);

   logic [HW-1:0] hcnt;
   logic [PW-1:0] pcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dclk <= 1'b0;
         hcnt <= '0;
      end else if (bit_stb) begin
         dclk <= 1'b1;
         hcnt <= '0;
      end else if (dclk && tick) begin
         if (hcnt == HLAST) dclk <= 1'b0;
         else               hcnt <= hcnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pcnt <= '0;
      else if (word_end) pcnt <= '0;
      else if (bit_stb)  pcnt <= pcnt + 1'b1;
   end

   AST_PULSES_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt <= PW'(DATA_W)); // R2

   AST_LOW_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |-> !dclk); // R2
endmodule

// File: rtl/fwp_host_port.sv
module fwp_host_port #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] word,
   input  logic              adv,
   output logic              bit_o,
   output logic              ready
);
   logic [DATA_W-1:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold  <= '0;
         ready <= 1'b0;
      end else if (load) begin
         hold  <= word;
         ready <= 1'b1;
      end else if (adv) begin
         hold  <= {1'b0, hold[DATA_W-1:1]};
         ready <= 1'b0;
      end
   end

   assign bit_o = hold[0];

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load) |=> !ready); // R9

   AST_LOAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (ready && bit_o == $past(word[0]))); // R10
endmodule

// File: rtl/fsk_word_port.sv
module fsk_word_port #(
   parameter int OSR         = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int HIGH_TICKS  = OSR / 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick16_i,
   input  logic mode_i,
   input  logic line_i,
   input  logic hclk_i,
   output logic data_o,
   output logic dclk_o,
   output logic dr_o
);
   if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
      $error("OSR must be even and at least 4");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (HIGH_TICKS < 1 || HIGH_TICKS >= OSR) begin : g_bad_high
      $error("HIGH_TICKS must lie in 1..OSR-1");
   end

   logic              line_s;
   logic              hclk_s;
   logic              hclk_d;
   logic              bit_stb;
   logic              word_vld;
   logic              frm_err;
   logic [DATA_W-1:0] word;
   logic              dclk_int;
   logic              host_bit;
   logic              host_rdy;
   logic              host_adv;
   logic              host_load;

   fwp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
      .clk(clk), .rst_n(rst_n), .d(line_i), .q(line_s));

   fwp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_hclk_sync (
      .clk(clk), .rst_n(rst_n), .d(hclk_i), .q(hclk_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hclk_d <= 1'b0;
      else        hclk_d <= hclk_s;
   end

   assign host_adv  = mode_i & hclk_s & ~hclk_d;
   assign host_load = mode_i & word_vld;

   fwp_rx_frame #(.OSR(OSR), .DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick16_i), .line(line_s),
      .bit_stb(bit_stb), .word_vld(word_vld), .frm_err(frm_err), .word(word));

   fwp_dclk_gen #(.OSR(OSR), .DATA_W(DATA_W), .HIGH_TICKS(HIGH_TICKS)) u_dclk (
      .clk(clk), .rst_n(rst_n), .tick(tick16_i), .bit_stb(bit_stb),
      .word_end(word_vld | frm_err), .dclk(dclk_int));

   fwp_host_port #(.DATA_W(DATA_W)) u_host (
      .clk(clk), .rst_n(rst_n), .load(host_load), .word(word),
      .adv(host_adv), .bit_o(host_bit), .ready(host_rdy));

   assign data_o = mode_i ? host_bit : line_i;
   assign dclk_o = mode_i ? 1'b0     : dclk_int;
   assign dr_o   = mode_i ? host_rdy : word_vld;

   AST_DR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i && dr_o) |=> (mode_i || !dr_o)); // R4
endmodule

// File: tb/fsk_word_port_tb.sv
module fsk_word_port_tb;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;
   localparam int NOM_BIT    = 16 * TICK_DIV;
   localparam int NVEC       = 6;

   localparam logic [7:0] V_BYTE [NVEC] = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81, 8'h5A};
   localparam int         V_STOP [NVEC] = '{1, 1, 3, 10, 1, 2};
   localparam int         V_LEN  [NVEC] = '{64, 64, 64, 64, 63, 65};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick16 = 1'b0;
   logic mode = 1'b0;
   logic line = 1'b1;
   logic hclk = 1'b0;
   logic data_o, dclk_o, dr_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int   rises = 0;
   int   drs = 0;
   int   bad_rise = 0;
   int   mism = 0;
   logic [7:0] cap = '0;
   bit   in_data = 1'b0;
   logic dclk_prev = 1'b0;
   int   div = 0;

   fsk_word_port u_dut (
      .clk(clk), .rst_n(rst_n), .tick16_i(tick16), .mode_i(mode),
      .line_i(line), .hclk_i(hclk), .data_o(data_o), .dclk_o(dclk_o), .dr_o(dr_o));

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      div    <= (div == TICK_DIV - 1) ? 0 : div + 1;
      tick16 <= (div == TICK_DIV - 1);
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (dclk_o && !dclk_prev) begin
            rises = rises + 1;
            cap   = {data_o, cap[7:1]};
            if (!in_data) bad_rise = bad_rise + 1;
         end
         if (!mode && dr_o) drs = drs + 1;
         if (!mode && data_o !== line) mism = mism + 1;
      end
      dclk_prev = dclk_o;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_mon();
      rises = 0; drs = 0; cap = '0;
   endtask

   task automatic send_frame(input logic [7:0] b, input int nstop, input int blen, input bit bad_stop);
      line = 1'b0;
      wait_clk(blen);
      in_data = 1'b1;
      for (int i = 0; i < 8; i++) begin
         line = b[i];
         wait_clk(blen);
      end
      in_data = 1'b0;
      if (bad_stop) begin
         line = 1'b0;
         wait_clk(blen);
         line = 1'b1;
         wait_clk(blen);
      end else begin
         line = 1'b1;
         wait_clk(nstop * blen);
      end
   endtask

   task automatic host_pulse();
      hclk = 1'b1;
      wait_clk(6);
      hclk = 1'b0;
      wait_clk(6);
   endtask

   initial begin
      wait_clk(5);
      chk("R11 dr in reset", int'(dr_o), 0);
      chk("R11 dclk in reset", int'(dclk_o), 0);
      rst_n = 1'b1;
      wait_clk(3 * NOM_BIT);
      chk("R11 dr after reset", int'(dr_o), 0);
      chk("R11 dclk after reset", int'(dclk_o), 0);

      // table walk in mode 0: R2 R4 R5 R6
      for (int v = 0; v < NVEC; v++) begin
         clear_mon();
         send_frame(V_BYTE[v], V_STOP[v], V_LEN[v], 1'b0);
         wait_clk(NOM_BIT);
         chk("R2 dclk edges per word", rises, 8);
         chk((V_LEN[v] != NOM_BIT) ? "R6 byte at off-rate" : "R2 captured byte", int'(cap), int'(V_BYTE[v]));
         chk((V_STOP[v] > 1) ? "R5 one ready with long stop" : "R4 ready pulses", drs, 1);
      end

      // R1 short low glitch
      clear_mon();
      line = 1'b0;
      wait_clk(4 * TICK_DIV);
      line = 1'b1;
      wait_clk(12 * NOM_BIT);
      chk("R1 glitch dclk edges", rises, 0);
      chk("R1 glitch ready", drs, 0);

      // R7 framing error then recovery
      clear_mon();
      send_frame(8'h6E, 1, NOM_BIT, 1'b1);
      wait_clk(NOM_BIT);
      chk("R7 no ready on bad stop", drs, 0);
      clear_mon();
      send_frame(8'h42, 1, NOM_BIT, 1'b0);
      wait_clk(NOM_BIT);
      chk("R7 recovery byte", int'(cap), 8'h42);
      chk("R7 recovery ready", drs, 1);

      chk("R3 data follows line", mism, 0);
      chk("R2 no edge in start or stop", bad_rise, 0);

      // host mode: R8 R9 R12
      mode = 1'b1;
      wait_clk(4);
      clear_mon();
      send_frame(8'hC6, 1, NOM_BIT, 1'b0);
      wait_clk(NOM_BIT);
      chk("R8 ready set", int'(dr_o), 1);
      chk("R12 dclk quiet", rises, 0);
      for (int k = 0; k < 8; k++) begin
         chk("R8 host bit", int'(data_o), int'(8'hC6 >> k) & 1);
         host_pulse();
         if (k == 0) chk("R9 ready cleared", int'(dr_o), 0);
      end

      // R10 overwrite during read
      send_frame(8'h93, 1, NOM_BIT, 1'b0);
      wait_clk(NOM_BIT);
      host_pulse();
      host_pulse();
      chk("R10 before overwrite bit2", int'(data_o), 0);
      chk("R10 ready low mid read", int'(dr_o), 0);
      send_frame(8'h2D, 1, NOM_BIT, 1'b0);
      wait_clk(NOM_BIT);
      chk("R10 ready again", int'(dr_o), 1);
      chk("R10 bit0 of new word", int'(data_o), 1);
      host_pulse();
      chk("R10 bit1 of new word", int'(data_o), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule